// File: doc/BRIEF.md
# Sequential Integer Divider with Range Fault

This block divides a dividend of twice the operand width by a divisor of one operand width. It produces a quotient and a remainder, each one operand width wide. The operand width is chosen for each operation as 8, 16 or 32 bits. A second control bit selects unsigned or two's-complement arithmetic. The surrounding logic places the operands on the inputs, pulses `start`, and waits for `done`. While the operation runs, `busy` is high.

The datapath works on magnitudes. It uses a restoring shift-subtract loop that retires one quotient bit per clock, then applies the signs. The signed quotient truncates toward zero and the remainder takes the sign of the dividend, so dividend = divisor × quotient + remainder always holds.

The operation is refused, and `fault` is raised together with `done`, in three cases:
- the divisor is zero;
- the quotient cannot be represented in the operand width;
- the quotient is exactly the most negative value and `legacy_mode` is set.

With `legacy_mode` clear, that most negative quotient is returned as a normal result. A refused operation leaves both result outputs unchanged.

Top module: `int_divider`

## Requirements
- R1: `op_size` selects the operand width w: 0 gives 8, 1 gives 16, and 2 or 3 give 32. Only the low 2w bits of `dividend` and the low w bits of `divisor` take part; higher input bits have no effect.
- R2: When `is_signed` is 0, a non-fault operation returns the unsigned quotient floor(dividend/divisor) and remainder dividend − divisor × quotient.
- R3: When `is_signed` is 1, operands are two's complement in their widths. The quotient truncates toward zero and a nonzero remainder has the sign of the dividend (for example −23 ÷ 5 gives −4 remainder −3, and 23 ÷ −5 gives −4 remainder 3).
- R4: A divisor whose low w bits are all zero ends the operation with `fault` = 1.
- R5: In unsigned mode, a quotient above 2^w − 1 faults (at 8 bits, 2560 ÷ 10 faults and 2555 ÷ 10 gives 255 remainder 5).
- R6: In signed mode, a quotient above 2^(w−1) − 1 faults (at 8 bits, 1280 ÷ 10 faults and 1275 ÷ 10 gives 127 remainder 5).
- R7: In signed mode with `legacy_mode` = 0, a quotient below −2^(w−1) faults and exactly −2^(w−1) is returned (1285 ÷ −10 at 8 bits gives quotient 80h, remainder 5).
- R8: In signed mode with `legacy_mode` = 1, a quotient equal to −2^(w−1) also faults.
- R9: On a fault, `quotient` and `remainder` keep the values they held before the operation, and `done` and `fault` are high together for that single cycle.
- R10: `busy` rises in the cycle after an accepted `start` and stays high until `done`. `done` is high for exactly one cycle per accepted operation. A `start` seen while `busy` is high is ignored.
- R11: After a non-fault operation, bits of `quotient` and `remainder` at positions w and above are zero.
- R12: After reset, `busy`, `done`, `fault`, `quotient` and `remainder` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| op_size | input | 2 | Operand width select (0: 8, 1: 16, 2/3: 32) |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| legacy_mode | input | 1 | 1: reject the most negative quotient |
| dividend | input | 64 | Double-width dividend, low 2w bits used |
| divisor | input | 32 | Divisor, low w bits used |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Operation refused, valid with `done` |
| quotient | output | 32 | Quotient, zero-extended from w bits |
| remainder | output | 32 | Remainder, zero-extended from w bits |

## Verification
The bench builds the divider with the default maximum width of 32. That makes all three operand widths reachable in one build, so the 8-, 16- and 32-bit boundaries can be driven back to back. These include the largest representable quotients, the first quotient past each limit, and the most negative quotient in both modes. A reference model that uses wide signed arithmetic produces the expected values. Runs of mixed random operations then exercise each sign combination at each width, and garbage above the active width confirms that those bits are ignored.

// File: rtl/div_pkg.sv
`timescale 1ns/1ps
package div_pkg;
    localparam int MAX_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;

    function automatic int width_of(input logic [1:0] sz);
        case (sz)
            2'd0:    return 8;
            2'd1:    return 16;
            default: return 32;
        endcase
    endfunction
endpackage

// File: rtl/div_prep.sv
`timescale 1ns/1ps
module div_prep #(
    parameter int W  = div_pkg::MAX_W,
    localparam int DW = 2 * W,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [1:0]    op_size,
    input  logic          is_signed,
    input  logic [DW-1:0] dividend,
    input  logic [W-1:0]  divisor,
    output logic [CW-1:0] width_o,
    output logic [W-1:0]  dvs_mag,
    output logic [W-1:0]  rem_init,
    output logic [W-1:0]  low_al,
    output logic          quo_neg,
    output logic          rem_neg,
    output logic          zero_div,
    output logic          early_ovf
);
    int            wi;
    logic [DW-1:0] m2, top2, dd_ext, dd_mag, hi;
    logic [W-1:0]  m1, top1, dv_ext, lo;
    logic          dd_s, dv_s;

    always_comb begin
        wi      = div_pkg::width_of(op_size);
        width_o = CW'(wi);
        m2      = (DW'(1) << (2 * wi)) - DW'(1);
        m1      = (W'(1) << wi) - W'(1);
        top2    = DW'(1) << (2 * wi - 1);
        top1    = W'(1) << (wi - 1);
        dd_s    = is_signed && ((dividend & top2) != '0);
        dv_s    = is_signed && ((divisor & top1) != '0);
        dd_ext  = (dividend & m2) | (dd_s ? ~m2 : '0);
        dv_ext  = (divisor & m1) | (dv_s ? ~m1 : '0);
        dd_mag  = dd_s ? (~dd_ext + DW'(1)) : dd_ext;
        dvs_mag = dv_s ? (~dv_ext + W'(1)) : dv_ext;
        hi      = dd_mag >> wi;
        rem_init = hi[W-1:0];
        lo      = dd_mag[W-1:0] & m1;
        low_al  = lo << (W - wi);
        quo_neg = dd_s ^ dv_s;
        rem_neg = dd_s;
        zero_div  = (divisor & m1) == '0;
        early_ovf = !zero_div && (rem_init >= dvs_mag);
    end
endmodule

// File: rtl/div_step.sv
`timescale 1ns/1ps
module div_step #(
    parameter int W = div_pkg::MAX_W
) (
    input  logic [W-1:0] rem_i,
    input  logic         bit_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic         q_o
);
    logic [W:0] ext;
    logic [W:0] dvx;

    always_comb begin
        ext   = {rem_i, bit_i};
        dvx   = {1'b0, dvs_i};
        q_o   = ext >= dvx;
        rem_o = W'(q_o ? (ext - dvx) : ext);
    end
endmodule

// File: rtl/div_range.sv
`timescale 1ns/1ps
module div_range #(
    parameter int W  = div_pkg::MAX_W,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  qmag,
    input  logic [CW-1:0] width_i,
    input  logic          is_signed,
    input  logic          neg,
    input  logic          legacy,
    output logic          ovf
);
    logic [W-1:0] lim;

    always_comb begin
        lim = W'(1) << (int'(width_i) - 1);
        ovf = 1'b0;
        if (is_signed) begin
            if (!neg)
                ovf = qmag >= lim;
            else
                ovf = (qmag > lim) || (legacy && (qmag == lim));
        end
    end
endmodule

// File: rtl/int_divider.sv
`timescale 1ns/1ps
module int_divider #(
    parameter int W  = div_pkg::MAX_W,
    localparam int DW = 2 * W,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op_size,
    input  logic          is_signed,
    input  logic          legacy_mode,
    input  logic [DW-1:0] dividend,
    input  logic [W-1:0]  divisor,
    output logic          busy,
    output logic          done,
    output logic          fault,
    output logic [W-1:0]  quotient,
    output logic [W-1:0]  remainder
);
    import div_pkg::*;

    typedef struct packed {
        div_state_e    state;
        logic [CW-1:0] cnt;
        logic [CW-1:0] width;
        logic [W-1:0]  dvs;
        logic [W-1:0]  rem;
        logic [W-1:0]  low;
        logic [W-1:0]  quo;
        logic          quo_neg;
        logic          rem_neg;
        logic          sgn;
        logic          legacy;
        logic          pend;
        logic          done;
        logic          fault;
        logic [W-1:0]  q_out;
        logic [W-1:0]  r_out;
    } regs_t;

    regs_t r_d, r_q;

    logic [CW-1:0] p_width;
    logic [W-1:0]  p_dvs, p_rem, p_low;
    logic          p_qneg, p_rneg, p_zero, p_early;
    logic [W-1:0]  s_rem;
    logic          s_bit;
    logic          rng_ovf;
    logic [W-1:0]  wmask;

    div_prep #(.W(W)) u_prep (
        .op_size   (op_size),
        .is_signed (is_signed),
        .dividend  (dividend),
        .divisor   (divisor),
        .width_o   (p_width),
        .dvs_mag   (p_dvs),
        .rem_init  (p_rem),
        .low_al    (p_low),
        .quo_neg   (p_qneg),
        .rem_neg   (p_rneg),
        .zero_div  (p_zero),
        .early_ovf (p_early)
    );

    div_step #(.W(W)) u_step (
        .rem_i (r_q.rem),
        .bit_i (r_q.low[W-1]),
        .dvs_i (r_q.dvs),
        .rem_o (s_rem),
        .q_o   (s_bit)
    );

    div_range #(.W(W)) u_range (
        .qmag      (r_q.quo),
        .width_i   (r_q.width),
        .is_signed (r_q.sgn),
        .neg       (r_q.quo_neg),
        .legacy    (r_q.legacy),
        .ovf       (rng_ovf)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = 1'b0;
        wmask     = (W'(1) << r_q.width) - W'(1);
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.width   = p_width;
                    r_d.cnt     = p_width;
                    r_d.dvs     = p_dvs;
                    r_d.rem     = p_rem;
                    r_d.low     = p_low;
                    r_d.quo     = '0;
                    r_d.quo_neg = p_qneg;
                    r_d.rem_neg = p_rneg;
                    r_d.sgn     = is_signed;
                    r_d.legacy  = legacy_mode;
                    r_d.pend    = p_zero || p_early;
                    r_d.state   = (p_zero || p_early) ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                r_d.rem = s_rem;
                r_d.low = r_q.low << 1;
                r_d.quo = {r_q.quo[W-2:0], s_bit};
                r_d.cnt = r_q.cnt - CW'(1);
                if (r_q.cnt == CW'(1))
                    r_d.state = ST_FIN;
            end
            ST_FIN: begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
                if (r_q.pend || rng_ovf) begin
                    r_d.fault = 1'b1;
                end else begin
                    r_d.q_out = (r_q.quo_neg ? (~r_q.quo + W'(1)) : r_q.quo) & wmask;
                    r_d.r_out = (r_q.rem_neg ? (~r_q.rem + W'(1)) : r_q.rem) & wmask;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign busy      = r_q.state != ST_IDLE;
    assign done      = r_q.done;
    assign fault     = r_q.fault;
    assign quotient  = r_q.q_out;
    assign remainder = r_q.r_out;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($stable(quotient) && $stable(remainder)));

    // R4
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && p_zero) |=> ##1 (done && fault));

    // R2
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN) |-> (r_q.rem < r_q.dvs));

    // R11
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (((quotient >> r_q.width) == '0) && ((remainder >> r_q.width) == '0)));
endmodule

// File: tb/int_divider_tb.sv
`timescale 1ns/1ps
module int_divider_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_size = 2'd0;
    logic        is_signed = 1'b0;
    logic        legacy_mode = 1'b0;
    logic [63:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy, done, fault;
    logic [31:0] quotient, remainder;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic        flt;
        logic [31:0] q;
        logic [31:0] r;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    logic [31:0] hold_q = '0;
    logic [31:0] hold_r = '0;

    always #10 clk = ~clk;

    int_divider u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_size(op_size),
        .is_signed(is_signed), .legacy_mode(legacy_mode),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .fault(fault), .quotient(quotient), .remainder(remainder)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic void model(input logic [1:0] sz, input logic sg, input logic lg,
                                  input logic [63:0] dd, input logic [31:0] dv,
                                  output logic flt, output logic [31:0] q, output logic [31:0] r);
        int w;
        logic [63:0] m2, ddm;
        logic [31:0] m1, dvm;
        logic signed [127:0] a, b, qq, rr, lo, hi;
        w   = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m2  = (w == 32) ? '1 : ((64'd1 << (2 * w)) - 64'd1);
        m1  = (w == 32) ? '1 : ((32'd1 << w) - 32'd1);
        ddm = dd & m2;
        dvm = dv & m1;
        a = $signed({64'd0, ddm});
        b = $signed({96'd0, dvm});
        if (sg) begin
            if (ddm[2*w-1]) a = a - (128'sd1 <<< (2 * w));
            if (dvm[w-1])   b = b - (128'sd1 <<< w);
        end
        q = hold_q;
        r = hold_r;
        if (b == 0) begin
            flt = 1'b1;
            return;
        end
        qq = a / b;
        rr = a % b;
        if (!sg) begin
            flt = qq > $signed({96'd0, m1});
        end else begin
            hi  = (128'sd1 <<< (w - 1)) - 128'sd1;
            lo  = -(128'sd1 <<< (w - 1));
            flt = (qq > hi) || (qq < lo) || (lg && (qq == lo));
        end
        if (!flt) begin
            q = qq[31:0] & m1;
            r = rr[31:0] & m1;
        end
    endfunction

    task automatic run_op(input logic [1:0] sz, input logic sg, input logic lg,
                          input logic [63:0] dd, input logic [31:0] dv, input string tag);
        exp_t e;
        model(sz, sg, lg, dd, dv, e.flt, e.q, e.r);
        e.tag = tag;
        if (!e.flt) begin
            hold_q = e.q;
            hold_r = e.r;
        end
        while (busy) @(negedge clk);
        exp_q.push_back(e);
        op_size = sz; is_signed = sg; legacy_mode = lg;
        dividend = dd; divisor = dv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {"R10 busy after start ", tag}, 64'(busy), 64'd1);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected done", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(fault == e.flt, {"fault ", e.tag}, 64'(fault), 64'(e.flt));
                chk(quotient == e.q, {"quotient ", e.tag}, 64'(quotient), 64'(e.q));
                chk(remainder == e.r, {"remainder ", e.tag}, 64'(remainder), 64'(e.r));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(busy == 0, "R12 busy", 64'(busy), 0);
        chk(done == 0, "R12 done", 64'(done), 0);
        chk(fault == 0, "R12 fault", 64'(fault), 0);
        chk(quotient == 0, "R12 quotient", 64'(quotient), 0);
        chk(remainder == 0, "R12 remainder", 64'(remainder), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R5 unsigned 8-bit boundaries
        run_op(2'd0, 0, 0, 64'd2550, 32'd10, "R2 u8 2550/10");
        run_op(2'd0, 0, 0, 64'd2555, 32'd10, "R5 u8 2555/10");
        run_op(2'd0, 0, 0, 64'd2560, 32'd10, "R5 u8 2560/10 fault");
        // R1 garbage above the active width
        run_op(2'd0, 0, 0, 64'hDEAD_BEEF_0000_09FB, 32'hABCD_EF0A, "R1 u8 upper bits ignored");
        // R6 signed positive limit
        run_op(2'd0, 1, 0, 64'd1275, 32'd10, "R6 s8 1275/10");
        run_op(2'd0, 1, 0, 64'd1280, 32'd10, "R6 s8 1280/10 fault");
        // R3 sign combinations
        run_op(2'd0, 1, 0, 64'hFFE9, 32'h05, "R3 s8 -23/5");
        run_op(2'd0, 1, 0, 64'd23, 32'hFB, "R3 s8 23/-5");
        run_op(2'd0, 1, 0, 64'hFFE9, 32'hFB, "R3 s8 -23/-5");
        run_op(2'd0, 1, 0, 64'd1270, 32'hF6, "R3 s8 1270/-10");
        // R7 / R8 most negative quotient
        run_op(2'd0, 1, 0, 64'd1285, 32'hF6, "R7 s8 1285/-10 accepted");
        run_op(2'd0, 1, 1, 64'd1285, 32'hF6, "R8 s8 1285/-10 legacy fault");
        run_op(2'd0, 1, 0, 64'd1295, 32'hF6, "R7 s8 below min fault");
        run_op(2'd1, 1, 0, 64'h0005_0005, 32'hFFF6, "R7 s16 min accepted");
        run_op(2'd1, 1, 1, 64'h0005_0005, 32'hFFF6, "R8 s16 min legacy fault");
        run_op(2'd2, 1, 0, 64'h5_0000_0005, 32'hFFFF_FFF6, "R7 s32 min accepted");
        run_op(2'd2, 1, 1, 64'h5_0000_0005, 32'hFFFF_FFF6, "R8 s32 min legacy fault");
        // R4 zero divisor, also with nonzero bits above the width
        run_op(2'd1, 0, 0, 64'd1234, 32'hFFFF_0000, "R4 u16 zero divisor");
        run_op(2'd2, 1, 0, 64'd99, 32'd0, "R4 s32 zero divisor");
        // R5 / R2 32-bit unsigned edges
        run_op(2'd2, 0, 0, 64'hFFFF_FFFE_0000_0001, 32'hFFFF_FFFF, "R2 u32 max quotient");
        run_op(2'd2, 0, 0, 64'hFFFF_FFFF_0000_0000, 32'hFFFF_FFFF, "R5 u32 overflow");
        run_op(2'd3, 0, 0, 64'h0000_0001_2345_6789, 32'h0000_0003, "R1 size 3 as 32");
        // R9 fault holds prior result
        run_op(2'd1, 0, 0, 64'd40000, 32'd7, "R11 u16 result");
        run_op(2'd1, 0, 0, 64'hFFFF_0000, 32'd7, "R9 u16 fault holds");

        // R10 start ignored while busy
        begin
            exp_t e;
            model(2'd2, 0, 0, 64'd1000000, 32'd3, e.flt, e.q, e.r);
            e.tag = "R10 start while busy ignored";
            hold_q = e.q; hold_r = e.r;
            exp_q.push_back(e);
            op_size = 2'd2; is_signed = 0; legacy_mode = 0;
            dividend = 64'd1000000; divisor = 32'd3;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (4) @(negedge clk);
            op_size = 2'd0; dividend = 64'd50; divisor = 32'd0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (exp_q.size() != 0) @(negedge clk);
            repeat (40) @(negedge clk);
            chk(busy == 0, "R10 no second operation", 64'(busy), 0);
        end

        // Mixed random operations across widths and signs (R2 R3 R5 R6 R7 R8 R11)
        for (int i = 0; i < 80; i++) begin
            logic [63:0] dd;
            logic [31:0] dv;
            logic [1:0]  sz;
            sz = 2'($urandom % 3);
            dd = {$urandom, $urandom} >> ($urandom % 64);
            dv = $urandom >> ($urandom % 32);
            if ($urandom % 2 == 1) dd = -dd;
            run_op(sz, 1'($urandom % 2), 1'($urandom % 2), dd, dv, "R3 mixed random");
        end

        repeat (5) @(negedge clk);
        summary();
    end
endmodule